// File: doc/BRIEF.md
# Word and Half-Word Addressable Memory

A small synchronous-write memory made of 32-bit words. It takes a byte address, and a single mode input switches the port between two kinds of access. In word mode the whole word at the word index is written and read. In half mode, address bit 1 picks one 16-bit half of that word, and only that half is written or shown.

Write data arrives as two 16-bit halves, and read data leaves as two 16-bit halves. In half mode the write data always comes from the low input half, and the read data always goes out on the low output half. Reads are combinational from the address. Writes take effect on the rising clock edge. The storage is two 16-bit banks, each with its own write enable, so a half write never touches the other half.

Top module: `word_half_mem`

## Requirements
- R1: With `full_mode`=1 and `wr_en`=1, the rising edge stores {`din_hi`,`din_lo`} into the word at index `addr[IDX_W+1:2]`. `din_hi` fills bits 31:16 and `din_lo` fills bits 15:0. Address bits 1 and 0 have no effect.
- R2: With `full_mode`=1, {`dout_hi`,`dout_lo`} shows the stored word at the addressed index in the same cycle, combinationally. A write is visible from the cycle after its edge.
- R3: With `full_mode`=0, `dout_hi` is all zeros.
- R4: With `full_mode`=0, `dout_lo` shows bits 15:0 of the addressed word when `addr[1]`=0, and bits 31:16 when `addr[1]`=1.
- R5: With `full_mode`=0 and `wr_en`=1, `din_lo` is stored into the half chosen by `addr[1]` (0 selects bits 15:0, 1 selects bits 31:16). `din_hi` has no effect.
- R6: A half-mode write leaves the other half of the word unchanged.
- R7: While `rst`=1, no write takes place.
- R8: Address bits above `IDX_W+1` are not decoded. With the default 64 words, addresses that differ only above bit 7 reach the same word.
- R9: With `wr_en`=0, no stored bit changes.
- R10: Address bit 0 has no effect in half mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes occur on the rising edge |
| rst | input | 1 | Synchronous active-high reset; blocks writes |
| addr | input | 32 | Byte address |
| wr_en | input | 1 | Write enable |
| full_mode | input | 1 | 1 selects word access, 0 selects half access |
| din_hi | input | 16 | High half of the write data |
| din_lo | input | 16 | Low half of the write data; the half-mode write data |
| dout_hi | output | 16 | High half of the read data; zero in half mode |
| dout_lo | output | 16 | Low half of the read data; the selected half in half mode |

## Verification
Because reads are combinational, a wrong stored half shows up at the ports in the very next cycle that addresses that word, with no added latency.

Several faults can be told apart by what reaches the outputs:
- A swapped bank enable or a crossed data steer turns a half-mode write into a corrupted neighbour half. A full-mode read-back exposes this at once.
- A write that slips through reset, or an aliasing error in the index decode, appears as an unexpected value on the first read-back of the affected word.

The directed sequences therefore read back both halves after every kind of write.

// File: rtl/wh_mem_pkg.sv
package wh_mem_pkg;
  // per-access steering produced by the address/mode decoder
  typedef struct packed {
    logic we_hi;   // write the upper bank
    logic we_lo;   // write the lower bank
    logic pick_hi; // half mode: upper bank is the selected half
  } wh_ctrl_t;
endpackage

// File: rtl/wh_addr_ctrl.sv
module wh_addr_ctrl #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 6
) (
  input  logic                   rst,
  input  logic [ADDR_W-1:0]      addr,
  input  logic                   wr_en,
  input  logic                   full_mode,
  output logic [IDX_W-1:0]       idx,
  output wh_mem_pkg::wh_ctrl_t   ctrl
);
  logic wr_ok;
  // bits above the decoded index and bit 0 carry no meaning here
  logic unused_addr_bits;

  assign unused_addr_bits = ^{addr[ADDR_W-1:IDX_W+2], addr[0]};
  assign idx   = addr[IDX_W+1:2];
  assign wr_ok = wr_en & ~rst;

  always_comb begin
    ctrl.pick_hi = addr[1];
    if (full_mode) begin
      ctrl.we_hi = wr_ok;
      ctrl.we_lo = wr_ok;
    end else begin
      ctrl.we_hi = wr_ok & addr[1];
      ctrl.we_lo = wr_ok & ~addr[1];
    end
  end
endmodule

// File: rtl/wh_bank.sv
module wh_bank #(
  parameter int DEPTH  = 64,
  parameter int HALF_W = 16,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [HALF_W-1:0] wdata,
  output logic [HALF_W-1:0] rdata
);
  logic [HALF_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
  end

  assign rdata = mem[idx];
endmodule

// File: rtl/wh_out_sel.sv
module wh_out_sel #(
  parameter int HALF_W = 16
) (
  input  logic              full_mode,
  input  logic              pick_hi,
  input  logic [HALF_W-1:0] hi_q,
  input  logic [HALF_W-1:0] lo_q,
  output logic [HALF_W-1:0] dout_hi,
  output logic [HALF_W-1:0] dout_lo
);
  always_comb begin
    if (full_mode) begin
      dout_hi = hi_q;
      dout_lo = lo_q;
    end else begin
      dout_hi = '0;
      dout_lo = pick_hi ? hi_q : lo_q;
    end
  end
endmodule

// File: rtl/word_half_mem.sv
module word_half_mem #(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 64,
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              full_mode,
  input  logic [HALF_W-1:0] din_hi,
  input  logic [HALF_W-1:0] din_lo,
  output logic [HALF_W-1:0] dout_hi,
  output logic [HALF_W-1:0] dout_lo
);
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int NBANKS = 2;

  logic [IDX_W-1:0]     idx;
  wh_mem_pkg::wh_ctrl_t ctrl;
  logic                 we_hi, we_lo;
  logic [HALF_W-1:0]    hi_q, lo_q;
  logic [HALF_W-1:0]    bank_wd [NBANKS];
  logic [HALF_W-1:0]    bank_rd [NBANKS];
  logic                 bank_we [NBANKS];

  wh_addr_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_ctrl (
    .rst(rst), .addr(addr), .wr_en(wr_en), .full_mode(full_mode),
    .idx(idx), .ctrl(ctrl)
  );

  assign we_hi = ctrl.we_hi;
  assign we_lo = ctrl.we_lo;

  // bank 0 = bits 15:0, bank 1 = bits 31:16; half writes feed both from din_lo
  assign bank_we[0] = we_lo;
  assign bank_we[1] = we_hi;
  assign bank_wd[0] = din_lo;
  assign bank_wd[1] = full_mode ? din_hi : din_lo;

  for (genvar g = 0; g < NBANKS; g++) begin : g_bank
    wh_bank #(.DEPTH(DEPTH), .HALF_W(HALF_W), .IDX_W(IDX_W)) u_bank (
      .clk(clk), .we(bank_we[g]), .idx(idx),
      .wdata(bank_wd[g]), .rdata(bank_rd[g])
    );
  end

  assign lo_q = bank_rd[0];
  assign hi_q = bank_rd[1];

  wh_out_sel #(.HALF_W(HALF_W)) u_out (
    .full_mode(full_mode), .pick_hi(ctrl.pick_hi),
    .hi_q(hi_q), .lo_q(lo_q), .dout_hi(dout_hi), .dout_lo(dout_lo)
  );
endmodule

// File: rtl/wh_mem_checker.sv
module wh_mem_checker #(
  parameter int ADDR_W = 32,
  parameter int HALF_W = 16,
  parameter int IDX_W  = 6
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic              full_mode,
  input logic [HALF_W-1:0] din_hi,
  input logic [HALF_W-1:0] din_lo,
  input logic [HALF_W-1:0] dout_hi,
  input logic [HALF_W-1:0] dout_lo,
  input logic [IDX_W-1:0]  idx,
  input logic              we_hi,
  input logic              we_lo,
  input logic [HALF_W-1:0] hi_q,
  input logic [HALF_W-1:0] lo_q
);
  a_r3_half_high_zero: assert property (@(posedge clk) disable iff (rst)
    !full_mode |-> dout_hi == '0);

  a_r4_half_low_pick: assert property (@(posedge clk) disable iff (rst)
    (!full_mode && !addr[1]) |-> dout_lo == lo_q);

  a_r5_half_single_bank: assert property (@(posedge clk) disable iff (rst)
    !full_mode |-> $onehot0({we_hi, we_lo}));

  a_r2_full_write_seen: assert property (@(posedge clk) disable iff (rst)
    (full_mode && wr_en) ##1 (full_mode && idx == $past(idx))
    |-> {dout_hi, dout_lo} == {$past(din_hi), $past(din_lo)});

  a_r6_other_half_kept: assert property (@(posedge clk) disable iff (rst)
    (!full_mode && wr_en && addr[1]) ##1 (idx == $past(idx))
    |-> lo_q == $past(lo_q));
endmodule

bind word_half_mem wh_mem_checker #(
  .ADDR_W(ADDR_W), .HALF_W(HALF_W), .IDX_W(IDX_W)
) u_wh_chk (
  .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .full_mode(full_mode),
  .din_hi(din_hi), .din_lo(din_lo), .dout_hi(dout_hi), .dout_lo(dout_lo),
  .idx(idx), .we_hi(we_hi), .we_lo(we_lo), .hi_q(hi_q), .lo_q(lo_q)
);

// File: tb/test_word_half_mem.sv
module test_word_half_mem;
  logic        clk = 0;
  logic        rst = 1;
  logic [31:0] addr = '0;
  logic        wr_en = 0;
  logic        full_mode = 1;
  logic [15:0] din_hi = '0, din_lo = '0;
  logic [15:0] dout_hi, dout_lo;
  int checks = 0, errors = 0;
  logic [31:0] mdl [64];

  always #5 clk = ~clk;

  word_half_mem i_word_half_mem (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .full_mode(full_mode),
    .din_hi(din_hi), .din_lo(din_lo), .dout_hi(dout_hi), .dout_lo(dout_lo)
  );

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  // one write cycle; the model follows the requirements
  task automatic do_write(logic [31:0] a, logic f, logic [15:0] h, logic [15:0] l);
    @(negedge clk);
    addr = a; full_mode = f; din_hi = h; din_lo = l; wr_en = 1;
    if (!rst) begin
      if (f) mdl[a[7:2]] = {h, l};
      else if (a[1]) mdl[a[7:2]][31:16] = l;
      else mdl[a[7:2]][15:0] = l;
    end
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic do_read(logic [31:0] a, logic f, output logic [31:0] q);
    @(negedge clk);
    addr = a; full_mode = f; wr_en = 0;
    #1 q = {dout_hi, dout_lo};
  endtask

  task automatic t_reset_state;
    logic [31:0] q;
    do_read(32'h0, 0, q);
    check("R3 reset half hi zero", {16'h0, q[31:16]}, 32'h0);
  endtask

  task automatic t_full_words;
    logic [31:0] q;
    for (int i = 0; i < 64; i++) do_write(i * 4 + (i % 4), 1, 16'hA000 + 16'(i), 16'h5000 + 16'(i));
    do_read(32'h14, 1, q); check("R1 full write word 5", q, mdl[5]);
    do_read(32'h17, 1, q); check("R1 A1 A0 ignored", q, mdl[5]);
    do_read(32'hFC, 1, q); check("R2 full read last word", q, mdl[63]);
    do_write(32'h20, 1, 16'h1234, 16'h5678);
    do_read(32'h20, 1, q); check("R2 next cycle visible", q, 32'h12345678);
  endtask

  task automatic t_half_reads;
    logic [31:0] q;
    do_read(32'h20, 0, q); check("R4 low half", q, 32'h00005678);
    do_read(32'h22, 0, q); check("R4 high half", q, 32'h00001234);
    do_read(32'h23, 0, q); check("R10 A0 ignored half", q, 32'h00001234);
    check("R3 half hi zero", {16'h0, q[31:16]}, 32'h0);
  endtask

  task automatic t_half_writes;
    logic [31:0] q;
    do_write(32'h22, 0, 16'hFFFF, 16'hBEEF);
    do_read(32'h20, 1, q); check("R5 R6 high half write", q, 32'hBEEF5678);
    do_write(32'h21, 0, 16'hFFFF, 16'hCAFE);
    do_read(32'h20, 1, q); check("R5 R6 low half write", q, 32'hBEEFCAFE);
    do_read(32'h24, 1, q); check("R6 neighbour word kept", q, mdl[9]);
  endtask

  task automatic t_alias_and_guards;
    logic [31:0] q;
    do_write(32'hABCD_0010, 1, 16'h0F0F, 16'hF0F0);
    do_read(32'h10, 1, q); check("R8 upper bits alias", q, 32'h0F0FF0F0);
    @(negedge clk); addr = 32'h10; full_mode = 1; din_hi = 16'h1111; din_lo = 16'h2222; wr_en = 0;
    @(negedge clk);
    do_read(32'h10, 1, q); check("R9 no write when disabled", q, 32'h0F0FF0F0);
    @(negedge clk); rst = 1;
    do_write(32'h10, 1, 16'h3333, 16'h4444);
    @(negedge clk); rst = 0;
    do_read(32'h10, 1, q); check("R7 reset blocks write", q, 32'h0F0FF0F0);
  endtask

  initial begin
    #10000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    t_reset_state();
    @(negedge clk); rst = 0;
    t_full_words();
    t_half_reads();
    t_half_writes();
    t_alias_and_guards();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule